// File: doc/BRIEF.md
# Polled and Interrupt Character Receive Port

This block connects a simple processor bus to one byte-wide receiving character device. The device hands over one byte per cycle strobe together with a parity bit. Each byte is held in a small first-in first-out buffer until software collects it. Software learns that a byte is waiting in one of two ways. It can spin on the top bit of a 32-bit status word. It can also enable a level interrupt request.

The port answers three word offsets above a base address: status at +0, data at +4 and control at +8. Read data is combinational and is valid in the same cycle as the request. A read of the data offset removes the oldest byte at the next clock edge. Bytes that arrive with odd overall parity set a sticky error flag. Software clears that flag by writing a one to it.

Top module: `pio_char_port`

## Requirements
- R1: After reset the status word reads 0, the control word reads 0 and `irq` is 0.
- R2: Only the addresses BASE_ADDR+0, +4 and +8 respond. A read of any other address returns 0, and a write to any other address changes nothing.
- R3: Status bit 31 is 1 exactly when the receive buffer holds at least one byte.
- R4: A read at offset +4 returns the oldest buffered byte in bits 7:0 with bits 31:8 at zero, and removes that byte. Bytes leave in their order of arrival.
- R5: A read at offset +4 while the buffer is empty returns 0 and leaves every state unchanged.
- R6: The buffer holds DEPTH bytes (default 4). A byte that arrives while the buffer is full is discarded.
- R7: Parity is even: a byte is in error when its eight bits plus `dev_par` hold an odd number of ones. An error sets status bit 0, and the byte is still stored.
- R8: Status bit 0 is sticky. Writing status with bit 0 = 1 clears it, and writing bit 0 = 0 leaves it set. If a bad byte arrives in the same cycle as the clear, the flag is set.
- R9: Control bit 0 is the interrupt enable and reads back as written. All other control bits read 0.
- R10: `irq` is 1 exactly while the interrupt enable is 1 and the buffer is non-empty. It drops in the cycle after the last byte is read.
- R11: Writes to offset +4 are ignored. They neither add to nor remove from the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, 0 when not a hit read |
| dev_valid | input | 1 | Device presents a byte this cycle |
| dev_byte | input | 8 | Received byte |
| dev_par | input | 1 | Parity bit sent with the byte |
| irq | output | 1 | Level interrupt request |

## Verification
The bench fills the buffer past its depth. A design that wraps a pointer wrongly or overwrites stored data would return bytes out of order or hand back a discarded byte. It reads the empty data register, where a careless pop would corrupt the count or raise ready. It probes neighbouring unmapped offsets, where a partial decode would alias onto the control or status register. It also drives a bad-parity byte in the same cycle as the clear write. A design that gives the clear priority would lose that error.

// File: rtl/pio_char_pkg.sv
// Shared constants for the character receive port.
// Assumes word-aligned offsets inside a 16-byte window.
package pio_char_pkg;
    localparam logic [3:0] OFS_STATUS = 4'h0;
    localparam logic [3:0] OFS_DATA   = 4'h4;
    localparam logic [3:0] OFS_CTRL   = 4'h8;
    localparam int READY_BIT = 31;
    localparam int PERR_BIT  = 0;
    localparam int IEN_BIT   = 0;

    typedef struct packed {
        logic status;
        logic data;
        logic ctrl;
    } reg_hit_t;
endpackage

// File: rtl/pio_char_dec.sv
// Address decoder: produces a one-hot register hit for the three mapped words.
// Assumes BASE_ADDR is 16-byte aligned; any other address yields no hit.
module pio_char_dec
    import pio_char_pkg::*;
#(
    parameter int          ADDR_W    = 32,
    parameter logic [31:0] BASE_ADDR = 32'h4000_0100
) (
    input  logic [ADDR_W-1:0] addr_i,
    output reg_hit_t          hit_o
);
    localparam int HI_W = ADDR_W - 4;
    localparam logic [HI_W-1:0] BASE_HI = BASE_ADDR[ADDR_W-1:4];

    logic in_window;

    // Compare the upper address bits against the base, then the offset.
    always_comb begin
        in_window     = (addr_i[ADDR_W-1:4] == BASE_HI);
        hit_o.status  = in_window && (addr_i[3:0] == OFS_STATUS);
        hit_o.data    = in_window && (addr_i[3:0] == OFS_DATA);
        hit_o.ctrl    = in_window && (addr_i[3:0] == OFS_CTRL);
    end
endmodule

// File: rtl/pio_char_parity.sv
// Even-parity checker for one received symbol.
// Assumes the parity bit makes the total count of ones even.
module pio_char_parity #(
    parameter int BYTE_W = 8
) (
    input  logic [BYTE_W-1:0] byte_i,
    input  logic              par_i,
    output logic              bad_o
);
    // Odd total number of ones means a parity error.
    always_comb bad_o = ^{byte_i, par_i};
endmodule

// File: rtl/pio_char_fifo.sv
// Receive buffer: DEPTH-entry first-in first-out store with an occupancy count.
// Assumes the caller never pushes when full and never pops when empty.
module pio_char_fifo #(
    parameter int BYTE_W = 8,
    parameter int DEPTH  = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push_i,
    input  logic [BYTE_W-1:0]          din_i,
    input  logic                       pop_i,
    output logic [BYTE_W-1:0]          dout_o,
    output logic                       empty_o,
    output logic                       full_o,
    output logic [$clog2(DEPTH+1)-1:0] fill_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH+1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [BYTE_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [CNT_W-1:0]  fill;

    // Storage write; no reset needed for the data array.
    always_ff @(posedge clk) begin
        if (push_i) mem[wr_ptr] <= din_i;
    end

    // Pointer and occupancy update with wrap at DEPTH-1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (push_i) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (pop_i)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            case ({push_i, pop_i})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end

    // Flags and head-of-queue output.
    always_comb begin
        dout_o  = mem[rd_ptr];
        empty_o = (fill == '0);
        full_o  = (fill == FULL_CNT);
        fill_o  = fill;
    end
endmodule

// File: rtl/pio_char_port.sv
// Character receive port: bus registers, receive buffer, parity flag, interrupt.
// Assumes one-cycle bus accesses with combinational read data.
module pio_char_port
    import pio_char_pkg::*;
#(
    parameter int          ADDR_W    = 32,
    parameter logic [31:0] BASE_ADDR = 32'h4000_0100,
    parameter int          DEPTH     = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_we,
    input  logic [31:0] bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        dev_valid,
    input  logic [7:0]  dev_byte,
    input  logic        dev_par,
    output logic        irq
);
    localparam int BYTE_W = 8;
    localparam int DATA_W = 32;
    localparam int CNT_W  = $clog2(DEPTH+1);

    reg_hit_t          hit;
    logic              rd_req, wr_req, pop, push;
    logic              empty, full, par_bad;
    logic [BYTE_W-1:0] head;
    logic [CNT_W-1:0]  fill;
    logic              ien, perr;

    pio_char_dec #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
        .addr_i (bus_addr[ADDR_W-1:0]),
        .hit_o  (hit)
    );

    pio_char_parity #(.BYTE_W(BYTE_W)) u_par (
        .byte_i (dev_byte),
        .par_i  (dev_par),
        .bad_o  (par_bad)
    );

    pio_char_fifo #(.BYTE_W(BYTE_W), .DEPTH(DEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (push),
        .din_i   (dev_byte),
        .pop_i   (pop),
        .dout_o  (head),
        .empty_o (empty),
        .full_o  (full),
        .fill_o  (fill)
    );

    // Bus strobes and buffer handshakes.
    always_comb begin
        rd_req = bus_sel && !bus_we;
        wr_req = bus_sel && bus_we;
        pop    = rd_req && hit.data && !empty;
        push   = dev_valid && !full;
    end

    // Interrupt-enable register.
    always_ff @(posedge clk) begin
        if (!rst_n)                ien <= 1'b0;
        else if (wr_req && hit.ctrl) ien <= bus_wdata[IEN_BIT];
    end

    // Sticky parity-error flag; a new error outranks a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n) perr <= 1'b0;
        else        perr <= (dev_valid && par_bad) ||
                            (perr && !(wr_req && hit.status && bus_wdata[PERR_BIT]));
    end

    // Read-data multiplexer.
    always_comb begin
        bus_rdata = '0;
        if (rd_req) begin
            if (hit.status) begin
                bus_rdata[READY_BIT] = !empty;
                bus_rdata[PERR_BIT]  = perr;
            end else if (hit.data) begin
                bus_rdata[BYTE_W-1:0] = empty ? '0 : head;
            end else if (hit.ctrl) begin
                bus_rdata[IEN_BIT] = ien;
            end
        end
        bus_rdata = bus_rdata & {DATA_W{1'b1}};
    end

    // Level interrupt request.
    always_comb irq = ien && !empty;
endmodule

// File: rtl/pio_char_port_chk.sv
// Property checker for pio_char_port, attached by bind.
// Assumes access to the buffer occupancy and the two flag registers.
module pio_char_port_chk #(
    parameter int          ADDR_W    = 32,
    parameter logic [31:0] BASE_ADDR = 32'h4000_0100,
    parameter int          DEPTH     = 4
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       bus_sel,
    input logic                       bus_we,
    input logic [31:0]                bus_addr,
    input logic [31:0]                bus_wdata,
    input logic [31:0]                bus_rdata,
    input logic                       dev_valid,
    input logic [7:0]                 dev_byte,
    input logic                       dev_par,
    input logic                       irq,
    input logic [$clog2(DEPTH+1)-1:0] fill,
    input logic                       ien,
    input logic                       perr
);
    logic miss, clr_wr;

    // Independent view of unmapped accesses and of the clear write.
    always_comb begin
        miss   = (bus_addr[31:4] != BASE_ADDR[31:4]) ||
                 !(bus_addr[3:0] == 4'h0 || bus_addr[3:0] == 4'h4 || bus_addr[3:0] == 4'h8);
        clr_wr = bus_sel && bus_we && (bus_addr == BASE_ADDR) && bus_wdata[0];
    end

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= ($clog2(DEPTH+1))'(DEPTH));

    assert_irq_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ien);

    assert_irq_empty_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (fill == '0) |-> !irq);

    assert_miss_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && miss && !dev_valid) |=> ($stable(fill) && $stable(ien) && $stable(perr)));

    assert_perr_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (perr && !clr_wr) |=> perr);

    assert_perr_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_valid && (^{dev_byte, dev_par})) |=> perr);

    assert_ready_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_we && bus_addr == BASE_ADDR) |-> (bus_rdata[31] == (fill != '0)));

    assert_empty_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_we && bus_addr == BASE_ADDR + 32'h4 && fill == '0) |-> (bus_rdata == '0));
endmodule

bind pio_char_port pio_char_port_chk #(
    .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .DEPTH(DEPTH)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dev_valid(dev_valid), .dev_byte(dev_byte), .dev_par(dev_par),
    .irq(irq), .fill(fill), .ien(ien), .perr(perr)
);

// File: tb/pio_char_port_tb.sv
// Scoreboard bench: device driver queues expected bytes, data reads pop and compare.
module pio_char_port_tb;
    localparam logic [31:0] BASE = 32'h4000_0100;
    localparam int DEPTH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [31:0] bus_addr = '0, bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        dev_valid = 1'b0;
    logic [7:0]  dev_byte = '0;
    logic        dev_par = 1'b0;
    logic        irq;

    int checks = 0, errors = 0;
    logic [7:0] exp_q [$];

    always #2 clk = ~clk;

    pio_char_port #(.BASE_ADDR(BASE), .DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .dev_valid(dev_valid), .dev_byte(dev_byte), .dev_par(dev_par), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_read(input logic [31:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 v = bus_rdata;
        @(posedge clk); #1;
        bus_sel = 1'b0;
    endtask

    task automatic bus_write(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    // Driver: sends a byte, queues it unless the buffer model is full.
    task automatic dev_send(input logic [7:0] b, input logic bad);
        @(negedge clk);
        dev_valid = 1'b1; dev_byte = b; dev_par = (^b) ^ bad;
        @(posedge clk); #1;
        dev_valid = 1'b0;
        if (exp_q.size() < DEPTH) exp_q.push_back(b);
    endtask

    // Monitor step: reads the data register and compares with the queue head.
    task automatic pop_check(input string req);
        logic [31:0] v;
        logic [7:0]  e;
        bus_read(BASE + 32'h4, v);
        e = (exp_q.size() > 0) ? exp_q.pop_front() : 8'h00;
        chk(req, v, {24'h0, e});
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        logic [31:0] v;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        bus_read(BASE, v);           chk("R1 status", v, 32'h0);
        bus_read(BASE + 32'h8, v);   chk("R1 ctrl", v, 32'h0);
        chk("R1 irq", {31'h0, irq}, 32'h0);

        bus_read(BASE + 32'h4, v);   chk("R5 empty data", v, 32'h0);
        bus_read(BASE, v);           chk("R5 status after empty read", v, 32'h0);

        dev_send(8'hA5, 1'b0); dev_send(8'h3C, 1'b0); dev_send(8'h01, 1'b0);
        bus_read(BASE, v);           chk("R3 ready set", v, 32'h8000_0000);
        chk("R10 irq off when disabled", {31'h0, irq}, 32'h0);

        bus_write(BASE + 32'h8, 32'hFFFF_FFFF);
        bus_read(BASE + 32'h8, v);   chk("R9 ctrl readback", v, 32'h1);
        chk("R10 irq on", {31'h0, irq}, 32'h1);

        bus_read(BASE + 32'hC, v);   chk("R2 unmapped offset", v, 32'h0);
        bus_read(BASE + 32'h14, v);  chk("R2 alias offset", v, 32'h0);
        bus_write(BASE + 32'h18, 32'h0);
        bus_write(BASE + 32'h1000, 32'h1);
        bus_read(BASE + 32'h8, v);   chk("R2 miss write ignored", v, 32'h1);

        bus_write(BASE + 32'h4, 32'h55);
        pop_check("R11/R4 first byte");
        pop_check("R4 second byte");
        chk("R10 irq held", {31'h0, irq}, 32'h1);
        pop_check("R4 third byte");
        chk("R10 irq drop", {31'h0, irq}, 32'h0);
        bus_read(BASE, v);           chk("R3 ready clear", v, 32'h0);

        for (int i = 0; i < DEPTH + 2; i++) dev_send(8'h10 + 8'(i), 1'b0);
        for (int i = 0; i < DEPTH; i++) pop_check("R6 full order");
        bus_read(BASE, v);           chk("R6 overflow dropped", v, 32'h0);

        dev_send(8'h7E, 1'b1);
        bus_read(BASE, v);           chk("R7 parity flag", v, 32'h8000_0001);
        pop_check("R7 bad byte stored");
        bus_read(BASE, v);           chk("R8 sticky", v, 32'h1);
        bus_write(BASE, 32'h0);
        bus_read(BASE, v);           chk("R8 write zero keeps", v, 32'h1);
        bus_write(BASE, 32'h1);
        bus_read(BASE, v);           chk("R8 clear", v, 32'h0);

        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = BASE; bus_wdata = 32'h1;
        dev_valid = 1'b1; dev_byte = 8'h03; dev_par = 1'b1;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_we = 1'b0; dev_valid = 1'b0;
        exp_q.push_back(8'h03);
        bus_read(BASE, v);           chk("R8 set beats clear", v, 32'h8000_0001);
        pop_check("R4 after collision");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule